// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This block chooses which of two source clocks drives a single output clock. The two sources run at frequencies that are integer multiples of each other, and the select input comes from logic clocked by one of them. Because select can change at any point in either source's cycle, a plain multiplexer could emit a shortened high phase or a narrow spike. This block prevents that.

Each source has one enable flop clocked on that source's falling edge, so an enable only changes while its own clock is low. Each flop samples the requested selection gated by the inverted enable of the other path. The outgoing clock is therefore shut off first, and the incoming clock is admitted only at its own next falling edge after that. The output is the OR of each clock ANDed with its enable. Reset clears both enables, so a source that never toggles cannot block the other one.

Top module: `glitchless_clk_mux`

## Requirements
- R1: With sel at 0 and the switch settled, clk_out copies clk0. With sel at 1, it copies clk1.
- R2: The enable of each path changes only while that path's source clock is low. It is updated on that source's falling edge.
- R3: The two path enables are never 1 at the same time. A path's enable rises only while the other path's enable is 0.
- R4: On a select change, the old source stops at its next falling edge. The new source starts at its first falling edge after that. With clk0 rising edges at times p and clk1 at twice that rate, edge-aligned, and select changing just after a clk0 rising edge, the next complete output pulse is the new source's high phase that begins one clk0 period later.
- R5: While rst (active high, asynchronous) is 1, both enables are 0 and clk_out stays low.
- R6: After reset, a source that never toggles does not prevent the other source from being selected and passed to clk_out.
- R7: Every high pulse on clk_out lasts exactly one full high phase of the selected source. There are no shortened or merged pulses during a switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | Source clock chosen when sel is 0 |
| clk1 | input | 1 | Source clock chosen when sel is 1 |
| rst | input | 1 | Asynchronous reset, active high; clears both enables |
| sel | input | 1 | Requested source: 0 for clk0, 1 for clk1 |
| clk_out | output | 1 | Switched output clock |

## Verification
The assertions assume that the two sources have a fixed phase relation. They also assume that sel never changes near a falling edge of either source, so each enable flop sees a settled value. The stimulus keeps to this. clk1 runs at exactly twice the frequency of clk0 with aligned rising edges, and sel changes only a short time after a clk0 rising edge, well away from any falling edge. Reset is asserted or released only while the selected source is low or its pulse has finished. The bench stops a source only while reset holds, so a stopped clock never makes a partial edge on an active path.

// File: rtl/glitchless_clk_mux.sv
module glitchless_clk_mux (
  input  logic clk0,
  input  logic clk1,
  input  logic rst,
  input  logic sel,
  output logic clk_out
);

  logic en0;
  logic en1;
  logic want0;
  logic want1;

  assign want0 = ~sel & ~en1;
  assign want1 =  sel & ~en0;

  always_ff @(negedge clk0 or posedge rst) begin
    if (rst) en0 <= 1'b0;
    else     en0 <= want0;
  end

  always_ff @(negedge clk1 or posedge rst) begin
    if (rst) en1 <= 1'b0;
    else     en1 <= want1;
  end

  assign clk_out = (clk0 & en0) | (clk1 & en1);

  // R1
  path0_follows_chk: assert property (@(negedge clk0) disable iff (rst)
    (!sel && !en1) |=> en0);

  // R1
  path1_follows_chk: assert property (@(negedge clk1) disable iff (rst)
    (sel && !en0) |=> en1);

  // R2
  always @(en0) if (!rst) en0_low_phase_chk: assert (!clk0);

  // R2
  always @(en1) if (!rst) en1_low_phase_chk: assert (!clk1);

  // R3
  excl_on_clk0_chk: assert property (@(posedge clk0) disable iff (rst)
    !(en0 && en1));

  // R3
  excl_on_clk1_chk: assert property (@(posedge clk1) disable iff (rst)
    !(en0 && en1));

  // R3
  handover1_chk: assert property (@(posedge clk1) disable iff (rst)
    $rose(en1) |-> !en0);

  // R3
  handover0_chk: assert property (@(posedge clk0) disable iff (rst)
    $rose(en0) |-> !en1);

  // R5
  reset_clear_chk: assert property (@(posedge clk0)
    rst |-> (!en0 && !en1 && !clk_out));

endmodule

// File: tb/glitchless_clk_mux_test.sv
`timescale 1ns/10ps
module glitchless_clk_mux_test;

  localparam real P0 = 5.0;
  localparam real H0 = P0 / 2.0;
  localparam real H1 = P0 / 4.0;

  logic clk0_raw = 1'b0;
  logic clk1_raw = 1'b1;
  logic run0 = 1'b1;
  logic run1 = 1'b1;
  logic clk0, clk1;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic clk_out;

  int checks = 0;
  int fails = 0;
  real expq[$];
  real t_rise = 0.0;
  bit  seen = 1'b0;
  bit  done = 1'b0;

  always #(H0) clk0_raw = ~clk0_raw;
  always #(H1) clk1_raw = ~clk1_raw;
  assign clk0 = clk0_raw & run0;
  assign clk1 = clk1_raw & run1;

  glitchless_clk_mux uut (
    .clk0(clk0), .clk1(clk1), .rst(rst), .sel(sel), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string tag, input real act, input real expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.3f expected=%0.3f at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor: each output pulse pops one expected width (R1 R4 R7)
  always @(posedge clk_out) begin
    t_rise = $realtime;
    seen = 1'b1;
  end

  always @(negedge clk_out) begin
    if (seen) begin
      real w;
      real e;
      w = $realtime - t_rise;
      seen = 1'b0;
      if (expq.size() == 0) chk(1'b0, "R7 unexpected pulse", w, 0.0);
      else begin
        e = expq.pop_front();
        chk((w > e - 0.01) && (w < e + 0.01), "R1 R4 R7 pulse width", w, e);
      end
    end
  end

  // driver: hold sel for n clk0 periods, push expected pulses
  task automatic seg(input bit s, input int n, input bit from_reset1);
    int cnt;
    sel = s;
    if (!s) cnt = n;
    else if (from_reset1) cnt = 2 * n;
    else cnt = 2 * n - 1;
    for (int i = 0; i < cnt; i++) expq.push_back(s ? H1 : H0);
    for (int i = 0; i < n; i++) @(posedge clk0_raw);
    #0.5;
  endtask

  task automatic reset_idle(input string tag);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk0_raw); #0.3;
      chk(clk_out == 1'b0, tag, real'(clk_out), 0.0);
    end
  endtask

  initial begin
    #(200000 * P0);
    chk(1'b0, "watchdog", 0.0, 1.0);
    summary();
  end

  initial begin
    // R5: output held low in reset
    reset_idle("R5 reset output");
    @(posedge clk0_raw); #0.5;
    rst = 1'b0;
    seg(1'b0, 3, 1'b0);
    // R4: alternating switches with varied hold lengths
    for (int k = 0; k < 12; k++) begin
      seg(1'b1, 1 + (k % 4), 1'b0);
      seg(1'b0, 1 + ((k + 2) % 3), 1'b0);
    end
    #(H0);
    rst = 1'b1;
    reset_idle("R5 reset after run");
    chk(expq.size() == 0, "R4 pulse count", real'(expq.size()), 0.0);

    // R6: clk1 dead, clk0 still selectable
    run1 = 1'b0;
    @(posedge clk0_raw); #0.5;
    rst = 1'b0;
    seg(1'b0, 5, 1'b0);
    #(H0);
    rst = 1'b1;
    reset_idle("R6 idle after clk0 only");
    chk(expq.size() == 0, "R6 clk0 pulses with clk1 dead", real'(expq.size()), 0.0);

    // R6: clk0 dead, clk1 still selectable
    run1 = 1'b1;
    run0 = 1'b0;
    @(posedge clk0_raw); #0.5;
    rst = 1'b0;
    seg(1'b1, 5, 1'b1);
    #1.0;
    rst = 1'b1;
    reset_idle("R5 idle after clk1 only");
    chk(expq.size() == 0, "R6 clk1 pulses with clk0 dead", real'(expq.size()), 0.0);

    done = 1'b1;
    summary();
  end

endmodule